// File: doc/BRIEF.md
# Video Frame Pass Qualifier

This block sits behind a serial video link receiver and decides whether the decoded stream can be trusted. It watches the receiver lock level, the frame start and frame end strobes, a line-valid level, a pixel strobe and a parity-error pulse. From these it produces one registered PASS flag. PASS is earned by a programmable number of clean frames. It is withdrawn by a change in frame geometry, by a parity error or by a stalled stream, and each of these causes has its own way back.

A static configuration selects the frame threshold and enables or disables each check. The threshold is a 2-bit value. The checks are line-count comparison, line-size comparison, parity handling mode, watchdog disable and packet discard. A packet-valid input is passed to a packet-valid output. When discard is enabled, that output is held low while PASS is low.

Line size is the number of pixel strobes seen while line-valid is high. A line ends on the first clock at which line-valid is sampled low after being high. Line count is the number of line ends since the last frame start.

Top module: `frame_pass_qual`

## Requirements
- R1: While rst_n is low, pass_o is 0, and all counters, references and the watchdog period are cleared.
- R2: With thr_i = 0 and lock_i high, pass_o is 1 from the clock edge after lock_i is first sampled high.
- R3: With thr_i = N (1 to 3), pass_o rises at the edge that samples the frame end of the Nth consecutive valid frame after a clear. A valid frame is one that has no size change, no mode-1 parity error and no line-count change. The first frame after a clear only sets the references, and it still counts.
- R4: With chk_lines_i = 1, a frame end whose line count differs from the previous frame's count clears pass_o and the good-frame count, and that frame does not count. With chk_lines_i = 0, a change in line count has no effect.
- R5: With chk_size_i = 1, a line whose pixel count differs from the previous line's count clears pass_o at its line end, and the frame holding it does not count.
- R6: With par_mode_i = 0, pass_o is 0 for exactly the cycles after which par_err_i was sampled high. It then returns with no requalification.
- R7: With par_mode_i = 1, par_err_i clears pass_o and the good-frame count, and the current frame does not count.
- R8: The watchdog is armed when wdog_dis_i = 0 and thr_i != 0. Once two frame ends have measured a period P (the cycle count between them), pass_o is cleared whenever the cycles since the last frame end exceed 2*P. With thr_i = 0, the watchdog has no effect.
- R9: With wdog_dis_i = 1, a stalled stream does not clear pass_o.
- R10: pkt_vld_o equals pkt_vld_i when discard_en_i = 0. When discard_en_i = 1, it equals pkt_vld_i AND pass_o.
- R11: lock_i sampled low clears pass_o at the next edge. It also clears the good-frame count, both geometry references and the watchdog period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Receiver lock level |
| fs_i | input | 1 | Frame start strobe |
| fe_i | input | 1 | Frame end strobe |
| lv_i | input | 1 | Line-valid level |
| pix_i | input | 1 | Pixel strobe |
| par_err_i | input | 1 | Parity error pulse |
| thr_i | input | 2 | Valid frames required before PASS |
| chk_lines_i | input | 1 | Enable line-count check |
| chk_size_i | input | 1 | Enable line-size check |
| par_mode_i | input | 1 | 0: transient parity drop, 1: parity requalifies |
| wdog_dis_i | input | 1 | Disable the frame watchdog |
| discard_en_i | input | 1 | Drop packets while PASS is low |
| pkt_vld_i | input | 1 | Incoming packet valid |
| pass_o | output | 1 | Stream qualified |
| pkt_vld_o | output | 1 | Forwarded packet valid |

## Verification
On every cycle, the embedded assertions check the immediate effects on PASS. Loss of lock, a mode-0 parity error, a mode-1 parity error, a line-size change and a watchdog trip must each leave PASS low at the next edge. A rise in PASS under a non-zero threshold must come from a frame end or from a prior qualified state. Other behaviour only shows up in the bench scenarios, which compare against a cycle-by-cycle model. These include the exact frame on which PASS returns after each kind of clear, and the double disruption when geometry changes and then changes back. They also include the twice-period watchdog window, the disable bit and the zero threshold.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
  localparam int THR_W = 2;

  typedef logic [THR_W-1:0] thr_t;

  typedef struct packed {
    thr_t thr;
    logic chk_lines;
    logic chk_size;
    logic par_mode;
    logic wdog_dis;
    logic discard;
  } fpq_cfg_t;
endpackage

// File: rtl/fpq_geom.sv
module fpq_geom #(
  parameter int PIX_W = 12,
  parameter int LIN_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic fs_i,
  input  logic fe_i,
  input  logic lv_i,
  input  logic pix_i,
  input  logic chk_size_i,
  input  logic chk_lines_i,
  output logic size_chg_o,
  output logic lines_chg_o
);
  localparam logic [PIX_W-1:0] PIX_MAX = '1;
  localparam logic [LIN_W-1:0] LIN_MAX = '1;

  logic             lv_q, lv_n;
  logic [PIX_W-1:0] pix_q, pix_n, sref_q, sref_n;
  logic [LIN_W-1:0] lcnt_q, lcnt_n, lref_q, lref_n;
  logic             sok_q, sok_n, lok_q, lok_n;
  logic             line_end;

  assign line_end    = lv_q & ~lv_i;
  assign size_chg_o  = line_end & chk_size_i & sok_q & (pix_q != sref_q);
  assign lines_chg_o = fe_i & chk_lines_i & lok_q & (lcnt_q != lref_q);

  always_comb begin
    lv_n   = en_i & lv_i;
    pix_n  = pix_q;
    sref_n = sref_q;
    sok_n  = sok_q;
    lcnt_n = lcnt_q;
    lref_n = lref_q;
    lok_n  = lok_q;
    if (!en_i) begin
      pix_n  = '0;
      sref_n = '0;
      sok_n  = 1'b0;
      lcnt_n = '0;
      lref_n = '0;
      lok_n  = 1'b0;
    end else begin
      if (line_end) begin
        sref_n = pix_q;
        sok_n  = 1'b1;
        pix_n  = '0;
      end else if (lv_i && pix_i && pix_q != PIX_MAX) begin
        pix_n = pix_q + 1'b1;
      end
      if (fe_i) begin
        lref_n = lcnt_q;
        lok_n  = 1'b1;
      end
      if (fs_i) begin
        lcnt_n = '0;
      end else if (line_end && lcnt_q != LIN_MAX) begin
        lcnt_n = lcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_q   <= 1'b0;
      pix_q  <= '0;
      sref_q <= '0;
      sok_q  <= 1'b0;
      lcnt_q <= '0;
      lref_q <= '0;
      lok_q  <= 1'b0;
    end else begin
      lv_q   <= lv_n;
      pix_q  <= pix_n;
      sref_q <= sref_n;
      sok_q  <= sok_n;
      lcnt_q <= lcnt_n;
      lref_q <= lref_n;
      lok_q  <= lok_n;
    end
  end

  // R5
  size_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && line_end) |=> sok_q);
endmodule

// File: rtl/fpq_wdog.sv
module fpq_wdog #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic arm_i,
  input  logic fe_i,
  output logic fire_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] wcnt_q, wcnt_n, per_q, per_n;
  logic             seen_q, seen_n, pok_q, pok_n;

  assign fire_o = arm_i & pok_q & ({1'b0, wcnt_q} > {per_q, 1'b0});

  always_comb begin
    wcnt_n = wcnt_q;
    per_n  = per_q;
    seen_n = seen_q;
    pok_n  = pok_q;
    if (!en_i) begin
      wcnt_n = '0;
      per_n  = '0;
      seen_n = 1'b0;
      pok_n  = 1'b0;
    end else if (fe_i) begin
      per_n  = wcnt_q;
      pok_n  = seen_q;
      seen_n = 1'b1;
      wcnt_n = '0;
    end else if (wcnt_q != CNT_MAX) begin
      wcnt_n = wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      per_q  <= '0;
      seen_q <= 1'b0;
      pok_q  <= 1'b0;
    end else begin
      wcnt_q <= wcnt_n;
      per_q  <= per_n;
      seen_q <= seen_n;
      pok_q  <= pok_n;
    end
  end

  // R8
  wd_measure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pok_q && !$past(pok_q)) |-> $past(fe_i));
endmodule

// File: rtl/frame_pass_qual.sv
module frame_pass_qual
  import fpq_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int LIN_W = 12,
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_i,
  input  logic       fs_i,
  input  logic       fe_i,
  input  logic       lv_i,
  input  logic       pix_i,
  input  logic       par_err_i,
  input  logic [1:0] thr_i,
  input  logic       chk_lines_i,
  input  logic       chk_size_i,
  input  logic       par_mode_i,
  input  logic       wdog_dis_i,
  input  logic       discard_en_i,
  input  logic       pkt_vld_i,
  output logic       pass_o,
  output logic       pkt_vld_o
);
  fpq_cfg_t cfg;
  logic     size_chg, lines_chg, wd_fire, wd_arm;
  logic     perr_hard, clr;
  thr_t     gcnt_q, gcnt_n;
  logic     qual_q, qual_n, fbad_q, fbad_n, pass_q, pass_n;

  assign cfg = '{thr: thr_i, chk_lines: chk_lines_i, chk_size: chk_size_i,
                 par_mode: par_mode_i, wdog_dis: wdog_dis_i, discard: discard_en_i};

  assign wd_arm = ~cfg.wdog_dis & (cfg.thr != '0);

  fpq_geom #(.PIX_W(PIX_W), .LIN_W(LIN_W)) u_geom (
    .clk(clk), .rst_n(rst_n), .en_i(lock_i), .fs_i(fs_i), .fe_i(fe_i),
    .lv_i(lv_i), .pix_i(pix_i), .chk_size_i(cfg.chk_size),
    .chk_lines_i(cfg.chk_lines), .size_chg_o(size_chg), .lines_chg_o(lines_chg)
  );

  fpq_wdog #(.CNT_W(CNT_W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .en_i(lock_i), .arm_i(wd_arm), .fe_i(fe_i),
    .fire_o(wd_fire)
  );

  assign perr_hard = par_err_i & cfg.par_mode;
  assign clr       = size_chg | lines_chg | perr_hard | wd_fire;

  always_comb begin
    gcnt_n = gcnt_q;
    qual_n = qual_q;
    fbad_n = fbad_q;
    if (fs_i) fbad_n = 1'b0;
    if (size_chg || perr_hard) fbad_n = 1'b1;
    if (!lock_i) begin
      gcnt_n = '0;
      qual_n = 1'b0;
      fbad_n = 1'b0;
    end else if (clr) begin
      gcnt_n = '0;
      qual_n = 1'b0;
    end else if (cfg.thr == '0) begin
      qual_n = 1'b1;
    end else if (fe_i && !fbad_q) begin
      if (gcnt_q != '1) gcnt_n = gcnt_q + 1'b1;
      if (gcnt_n >= cfg.thr) qual_n = 1'b1;
    end
    pass_n = qual_n & ~(par_err_i & ~cfg.par_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt_q <= '0;
      qual_q <= 1'b0;
      fbad_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      gcnt_q <= gcnt_n;
      qual_q <= qual_n;
      fbad_q <= fbad_n;
      pass_q <= pass_n;
    end
  end

  assign pass_o    = pass_q;
  assign pkt_vld_o = pkt_vld_i & (~cfg.discard | pass_q);

  // R11
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |=> !pass_o);
  // R6
  par_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_i && !par_mode_i) |=> !pass_o);
  // R7
  par_hard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_i && par_mode_i) |=> !qual_q);
  // R5
  size_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_chg |=> !pass_o);
  // R8
  wdog_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> !pass_o);
  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pass_o) && thr_i != 2'd0 && $past(thr_i) != 2'd0) |-> ($past(fe_i) || $past(qual_q)));
endmodule

// File: tb/sim_frame_pass_qual.sv
`timescale 1ns/1ps
module sim_frame_pass_qual;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock = 0, fs = 0, fe = 0, lv = 0, pix = 0, perr = 0;
  logic [1:0] thr = 0;
  logic chk_l = 0, chk_s = 0, pmode = 0, wdis = 0, disc = 0, pkt = 0;
  logic pass, pkt_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  frame_pass_qual u0 (
    .clk(clk), .rst_n(rst_n), .lock_i(lock), .fs_i(fs), .fe_i(fe), .lv_i(lv),
    .pix_i(pix), .par_err_i(perr), .thr_i(thr), .chk_lines_i(chk_l),
    .chk_size_i(chk_s), .par_mode_i(pmode), .wdog_dis_i(wdis),
    .discard_en_i(disc), .pkt_vld_i(pkt), .pass_o(pass), .pkt_vld_o(pkt_o)
  );

  // behavioural reference model
  int m_g, m_pixc, m_rsize, m_lcnt, m_rlines, m_wcnt, m_per;
  bit m_qual, m_pass, m_fbad, m_lvq, m_rsok, m_rlok, m_seen, m_perok;
  bit e_le, e_sc, e_lc, e_fire, e_clr, e_nfb;
  int e_oldl, e_oldw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_g = 0; m_pixc = 0; m_rsize = 0; m_lcnt = 0; m_rlines = 0; m_wcnt = 0; m_per = 0;
      m_qual = 0; m_pass = 0; m_fbad = 0; m_lvq = 0; m_rsok = 0; m_rlok = 0;
      m_seen = 0; m_perok = 0;
    end else begin
      e_le   = m_lvq && !lv;
      e_sc   = e_le && chk_s && m_rsok && (m_pixc != m_rsize);
      e_lc   = fe && chk_l && m_rlok && (m_lcnt != m_rlines);
      e_fire = (thr != 0) && !wdis && m_perok && (m_wcnt > 2 * m_per);
      e_clr  = e_sc || e_lc || (perr && pmode) || e_fire;
      e_nfb  = m_fbad;
      if (fs) e_nfb = 0;
      if (e_sc || (perr && pmode)) e_nfb = 1;
      if (!lock) begin m_g = 0; m_qual = 0; e_nfb = 0; end
      else if (e_clr) begin m_g = 0; m_qual = 0; end
      else if (thr == 0) m_qual = 1;
      else if (fe && !m_fbad) begin
        if (m_g < 3) m_g++;
        if (m_g >= thr) m_qual = 1;
      end
      m_pass = m_qual && !(perr && !pmode);
      m_fbad = e_nfb;
      e_oldl = m_lcnt;
      e_oldw = m_wcnt;
      if (!lock) begin
        m_pixc = 0; m_rsize = 0; m_rsok = 0; m_lcnt = 0; m_rlines = 0; m_rlok = 0;
        m_wcnt = 0; m_per = 0; m_seen = 0; m_perok = 0;
      end else begin
        if (e_le) begin m_rsize = m_pixc; m_rsok = 1; m_pixc = 0; end
        else if (lv && pix) m_pixc++;
        if (fe) begin m_rlines = e_oldl; m_rlok = 1; end
        if (fs) m_lcnt = 0; else if (e_le) m_lcnt++;
        if (fe) begin m_per = e_oldw; m_perok = m_seen; m_seen = 1; m_wcnt = 0; end
        else m_wcnt++;
      end
      m_lvq = lock && lv;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (pass !== m_pass) begin
        bad++;
        $display("FAIL model pass at %0t: actual=%0b expected=%0b", $time, pass, m_pass);
      end
      total++;
      if (pkt_o !== (pkt && (!disc || m_pass))) begin
        bad++;
        $display("FAIL R10 model fwd at %0t: actual=%0b expected=%0b", $time, pkt_o,
                 pkt && (!disc || m_pass));
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic frame(input int nl, input int np, input int badl, input int badnp);
    fs = 1; step(1); fs = 0;
    for (int l = 0; l < nl; l++) begin
      lv = 1; pix = 1;
      step((l == badl) ? badnp : np);
      lv = 0; pix = 0;
      step(1);
    end
    fe = 1; step(1); fe = 0;
    step(2);
  endtask

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pkt = 1;
    step(3);
    chk(pass, 1'b0, "R1 pass in reset");
    chk(pkt_o, 1'b1, "R10 forward with discard off");
    rst_n = 1;
    step(2);
    chk(pass, 1'b0, "R1 pass after reset, no lock");

    // R2 zero threshold
    lock = 1; step(1);
    chk(pass, 1'b1, "R2 thr0 pass after lock");

    // R3 threshold of 2
    thr = 2; lock = 0; step(1);
    chk(pass, 1'b0, "R11 lock loss clears");
    lock = 1; step(1);
    frame(3, 4, -1, 0);
    chk(pass, 1'b0, "R3 one frame of two");
    frame(3, 4, -1, 0);
    chk(pass, 1'b1, "R3 two frames of two");

    // R4 line count disabled then enabled
    frame(4, 4, -1, 0);
    chk(pass, 1'b1, "R4 count change ignored when off");
    frame(3, 4, -1, 0);
    chk_l = 1;
    frame(4, 4, -1, 0);
    chk(pass, 1'b0, "R4 count change drops");
    frame(3, 4, -1, 0);
    frame(3, 4, -1, 0);
    chk(pass, 1'b0, "R4 requal in progress");
    frame(3, 4, -1, 0);
    chk(pass, 1'b1, "R4 requalified");
    chk_l = 0;

    // R5 line size
    chk_s = 1;
    frame(3, 4, 1, 6);
    chk(pass, 1'b0, "R5 size change drops");
    frame(3, 4, -1, 0);
    frame(3, 4, -1, 0);
    frame(3, 4, -1, 0);
    chk(pass, 1'b1, "R5 requalified");
    chk_s = 0;

    // R6 parity mode 0
    perr = 1; step(1); perr = 0;
    chk(pass, 1'b0, "R6 transient drop");
    step(1);
    chk(pass, 1'b1, "R6 immediate return");

    // R7 parity mode 1
    pmode = 1;
    perr = 1; step(1); perr = 0; step(2);
    chk(pass, 1'b0, "R7 hard drop holds");
    frame(3, 4, -1, 0);
    chk(pass, 1'b0, "R7 one frame not enough");
    frame(3, 4, -1, 0);
    chk(pass, 1'b1, "R7 requalified");
    pmode = 0;

    // R8 watchdog
    thr = 1;
    frame(3, 4, -1, 0);
    frame(3, 4, -1, 0);
    chk(pass, 1'b1, "R8 pass before stall");
    step(60);
    chk(pass, 1'b0, "R8 stall trips watchdog");
    frame(3, 4, -1, 0);
    frame(3, 4, -1, 0);
    chk(pass, 1'b1, "R8 recovered");

    // R9 disable
    wdis = 1;
    step(80);
    chk(pass, 1'b1, "R9 stall ignored when disabled");
    wdis = 0;
    frame(3, 4, -1, 0);
    frame(3, 4, -1, 0);
    thr = 0;
    step(80);
    chk(pass, 1'b1, "R8 no effect at thr0");

    // R10 discard
    disc = 1;
    chk(pkt_o, 1'b1, "R10 forward when passing");
    lock = 0; step(1);
    chk(pkt_o, 1'b0, "R10 discard when not passing");
    pkt = 0; step(1);
    chk(pkt_o, 1'b0, "R10 idle packet");
    pkt = 1; lock = 1; step(1);
    chk(pkt_o, 1'b1, "R10 forward again");
    disc = 0;

    // R11 lock loss resets counting
    thr = 3;
    lock = 0; step(1); lock = 1; step(1);
    frame(3, 4, -1, 0);
    frame(3, 4, -1, 0);
    lock = 0; step(1);
    chk(pass, 1'b0, "R11 lock low");
    lock = 1; step(1);
    frame(3, 4, -1, 0);
    chk(pass, 1'b0, "R11 count restarted");
    frame(3, 4, -1, 0);
    frame(3, 4, -1, 0);
    chk(pass, 1'b1, "R3 three frames of three");

    step(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule